// File: doc/BRIEF.md
# Mixed-Signal Scope Trigger Unit

This block decides, one sample at a time, when a mixed-signal capture should start. Each sample tick presents a 10-bit analog code and an 8-bit logic word. The trigger can fire on an analog threshold crossing of a chosen polarity, on such a crossing qualified by the width of the pulse that follows, or on a masked match of the logic word. The block is set up through a small byte-wide write port. It is then armed. A programmable holdoff counts samples before any trigger is allowed. The block emits a single-cycle trigger pulse and then holds a triggered flag until it is re-armed.

The control flow is one state machine with five states. IDLE means disarmed. HOLDOFF counts samples after arming. SEEK waits for the trigger event. MEASURE times a pulse in the width modes. FIRED holds the result. The transitions are:
- arm: any state goes to HOLDOFF, or to SEEK when the holdoff is zero.
- holdoff done: HOLDOFF goes to SEEK.
- pulse start: SEEK goes to MEASURE on the selected crossing in a width mode.
- fire: SEEK or MEASURE goes to FIRED.
- width reject: MEASURE goes back to SEEK.
- FSM reset: any state goes to IDLE.

Configuration writes are accepted only in IDLE and FIRED.

Top module: `scope_trig_unit`

## Requirements
- R1: After rst_n is released, trig_pulse, triggered and armed are 0. Every configuration field is zero, so the holdoff is 0 and the pattern and mask are both 0x00.
- R2: The register map is as follows. Address 3 holds threshold bits [7:0]. Address 4 holds threshold bits [9:8] in [1:0], the falling-edge select in bit 2, the mode in [6:5] and the enable in bit 7. Address 5 is the logic pattern and address 6 is the mask. Addresses 7 and 8 are the holdoff low and high bytes. Address 11 is the width limit. Bits [4:3] of address 4 and all other addresses have no effect.
- R3: A sample is above the threshold when its code is greater than or equal to the threshold. A rising crossing is a tick that is above when the previous tick was not. A falling crossing is the reverse. The first tick after arming has no previous tick and is never a crossing. In mode 00 the trigger fires on the first crossing of the selected polarity.
- R4: In mode 11 the trigger fires on the first tick where ((logic XOR pattern) AND NOT mask) is zero. A mask bit of 1 ignores that channel. The analog input has no effect in this mode.
- R5: With the enable bit (address 4 bit 7) clear, no trigger fires and the unit stays armed.
- R6: After arming with holdoff N, the first N ticks cannot fire, even if they contain crossings. Those ticks still count as previous samples for crossing detection.
- R7: Pulse width is the number of ticks from the start crossing (counted as 1) up to, but not including, the opposite crossing. In mode 01 the trigger fires at the opposite crossing when the width is below the limit. Otherwise the unit resumes searching.
- R8: In mode 10 the trigger fires at the opposite crossing when the width is at or above the limit. A width equal to the limit fires.
- R9: The width count saturates at 255 instead of wrapping, so a 300-tick pulse passes a limit of 255.
- R10: trig_pulse is high for exactly the one cycle after the edge that sampled the deciding tick. triggered then stays high, and no second pulse occurs until the next arm.
- R11: Configuration writes are ignored while armed. Writes made in IDLE or FIRED take effect for the next arm.
- R12: fsm_reset returns the unit to IDLE (armed and triggered both 0) one edge later. It takes priority over a simultaneous arm.
- R13: armed is high in HOLDOFF, SEEK and MEASURE. armed and triggered are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write byte |
| arm | input | 1 | Start a new trigger search |
| fsm_reset | input | 1 | Return the state machine to IDLE |
| tick | input | 1 | Sample valid strobe |
| ana_sample | input | 10 | Analog sample code |
| la_sample | input | 8 | Logic channel sample |
| trig_pulse | output | 1 | One-cycle trigger event |
| triggered | output | 1 | Trigger has occurred since the last arm |
| armed | output | 1 | Unit is searching for a trigger |

## Verification
A wrong state shows up at armed and triggered in the cycle after the faulty transition. A lost previous-sample value or a wrong counter only shows at trig_pulse, when the deciding tick arrives early or late. The hardest errors to see are an off-by-one in holdoff or width and a wrapping width counter. The tests place crossings on the exact last holdoff tick and on a width equal to the limit, and run a pulse longer than the counter range, so that these errors change whether the trigger fires on a specific tick.

// File: rtl/scope_trig_pkg.sv
package scope_trig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLDOFF = 3'd1,
        ST_SEEK    = 3'd2,
        ST_MEASURE = 3'd3,
        ST_FIRED   = 3'd4
    } trig_state_e;

    typedef enum logic [1:0] {
        MODE_LEVEL   = 2'b00,
        MODE_NARROW  = 2'b01,
        MODE_WIDE    = 2'b10,
        MODE_PATTERN = 2'b11
    } trig_mode_e;

    localparam int CFG_ADDR_W = 4;
    localparam int BYTE_W     = 8;

    localparam logic [CFG_ADDR_W-1:0] A_THR_LO  = 4'd3;
    localparam logic [CFG_ADDR_W-1:0] A_CTRL    = 4'd4;
    localparam logic [CFG_ADDR_W-1:0] A_PATTERN = 4'd5;
    localparam logic [CFG_ADDR_W-1:0] A_MASK    = 4'd6;
    localparam logic [CFG_ADDR_W-1:0] A_HOLD_LO = 4'd7;
    localparam logic [CFG_ADDR_W-1:0] A_HOLD_HI = 4'd8;
    localparam logic [CFG_ADDR_W-1:0] A_WIDTH   = 4'd11;

endpackage

// File: rtl/scope_trig_regs.sv
module scope_trig_regs
    import scope_trig_pkg::*;
#(
    parameter int ANA_W  = 10,
    parameter int LA_W   = 8,
    parameter int WID_W  = 8,
    parameter int HOLD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  lock,
    output logic [ANA_W-1:0]      thr,
    output logic                  falling,
    output trig_mode_e            mode,
    output logic                  enable,
    output logic [LA_W-1:0]       pattern,
    output logic [LA_W-1:0]       mask,
    output logic [HOLD_W-1:0]     holdoff,
    output logic [WID_W-1:0]      width_lim
);

    localparam int THR_HI_W = ANA_W - BYTE_W;

    logic accept;
    assign accept = wr_en && !lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr       <= '0;
            falling   <= 1'b0;
            mode      <= MODE_LEVEL;
            enable    <= 1'b0;
            pattern   <= '0;
            mask      <= '0;
            holdoff   <= '0;
            width_lim <= '0;
        end else if (accept) begin
            unique case (wr_addr)
                A_THR_LO:  thr[BYTE_W-1:0] <= wr_data;
                A_CTRL: begin
                    thr[ANA_W-1:BYTE_W] <= wr_data[THR_HI_W-1:0];
                    falling             <= wr_data[2];
                    mode                <= trig_mode_e'(wr_data[6:5]);
                    enable              <= wr_data[7];
                end
                A_PATTERN: pattern <= wr_data[LA_W-1:0];
                A_MASK:    mask    <= wr_data[LA_W-1:0];
                A_HOLD_LO: holdoff[BYTE_W-1:0] <= wr_data;
                A_HOLD_HI: holdoff[HOLD_W-1:BYTE_W] <= wr_data;
                A_WIDTH:   width_lim <= wr_data[WID_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/scope_trig_detect.sv
module scope_trig_detect #(
    parameter int ANA_W = 10,
    parameter int LA_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [ANA_W-1:0] sample,
    input  logic [ANA_W-1:0] thr,
    input  logic             falling,
    input  logic [LA_W-1:0]  la,
    input  logic [LA_W-1:0]  pattern,
    input  logic [LA_W-1:0]  mask,
    output logic             start_x,
    output logic             end_x,
    output logic             match
);

    logic prev_valid;
    logic prev_above;
    logic cur_above;
    logic rise;
    logic fall;

    assign cur_above = (sample >= thr);
    assign rise      = tick && prev_valid && !prev_above && cur_above;
    assign fall      = tick && prev_valid && prev_above && !cur_above;
    assign start_x   = falling ? fall : rise;
    assign end_x     = falling ? rise : fall;
    assign match     = tick && (((la ^ pattern) & ~mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_above <= 1'b0;
        end else if (restart) begin
            prev_valid <= 1'b0;
            prev_above <= 1'b0;
        end else if (tick) begin
            prev_valid <= 1'b1;
            prev_above <= cur_above;
        end
    end

endmodule

// File: rtl/scope_trig_fsm.sv
module scope_trig_fsm
    import scope_trig_pkg::*;
#(
    parameter int WID_W  = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              fsm_reset,
    input  logic              tick,
    input  logic              start_x,
    input  logic              end_x,
    input  logic              match,
    input  trig_mode_e        mode,
    input  logic              enable,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic [WID_W-1:0]  width_lim,
    output logic              restart,
    output logic              trig_pulse,
    output logic              armed,
    output logic              triggered
);

    localparam logic [WID_W-1:0] WCNT_MAX = '1;

    trig_state_e       state, state_n;
    logic              fire;
    logic [HOLD_W-1:0] hcnt;
    logic [HOLD_W-1:0] hcnt_inc;
    logic              hold_last;
    logic [WID_W-1:0]  wcnt;
    logic              width_ok;

    assign hcnt_inc  = hcnt + HOLD_W'(1);
    assign hold_last = (hcnt_inc == holdoff);
    assign width_ok  = (mode == MODE_NARROW) ? (wcnt < width_lim)
                                             : (wcnt >= width_lim);
    assign restart   = arm || fsm_reset;

    // next state and fire decision
    always_comb begin
        state_n = state;
        fire    = 1'b0;
        if (fsm_reset) begin
            state_n = ST_IDLE;
        end else if (arm) begin
            state_n = (holdoff == '0) ? ST_SEEK : ST_HOLDOFF;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_HOLDOFF: begin
                    if (tick && hold_last) state_n = ST_SEEK;
                end
                ST_SEEK: begin
                    if (enable) begin
                        if (mode == MODE_PATTERN) begin
                            if (match) begin
                                fire    = 1'b1;
                                state_n = ST_FIRED;
                            end
                        end else if (start_x) begin
                            if (mode == MODE_LEVEL) begin
                                fire    = 1'b1;
                                state_n = ST_FIRED;
                            end else begin
                                state_n = ST_MEASURE;
                            end
                        end
                    end
                end
                ST_MEASURE: begin
                    if (end_x) begin
                        if (width_ok) begin
                            fire    = 1'b1;
                            state_n = ST_FIRED;
                        end else begin
                            state_n = ST_SEEK;
                        end
                    end
                end
                ST_FIRED: ;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // holdoff and width counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            wcnt <= '0;
        end else begin
            if (restart)
                hcnt <= '0;
            else if (state == ST_HOLDOFF && tick)
                hcnt <= hcnt_inc;

            if (state == ST_SEEK && state_n == ST_MEASURE)
                wcnt <= WID_W'(1);
            else if (state == ST_MEASURE && tick && wcnt != WCNT_MAX)
                wcnt <= wcnt + WID_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_pulse <= 1'b0;
        else        trig_pulse <= fire;
    end

    assign armed     = (state == ST_HOLDOFF) || (state == ST_SEEK) || (state == ST_MEASURE);
    assign triggered = (state == ST_FIRED);

endmodule

// File: rtl/scope_trig_unit.sv
module scope_trig_unit
    import scope_trig_pkg::*;
#(
    parameter int ANA_W = 10,
    parameter int LA_W  = 8,
    parameter int WID_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0]     cfg_wdata,
    input  logic                  arm,
    input  logic                  fsm_reset,
    input  logic                  tick,
    input  logic [ANA_W-1:0]      ana_sample,
    input  logic [LA_W-1:0]       la_sample,
    output logic                  trig_pulse,
    output logic                  triggered,
    output logic                  armed
);

    localparam int HOLD_W = 2 * BYTE_W;
    localparam int CFG_W  = ANA_W + 1 + 2 + 1 + 2 * LA_W + HOLD_W + WID_W;

    logic [ANA_W-1:0]  thr_q;
    logic              falling_q;
    trig_mode_e        mode_q;
    logic              enable_q;
    logic [LA_W-1:0]   pat_q;
    logic [LA_W-1:0]   mask_q;
    logic [HOLD_W-1:0] hold_q;
    logic [WID_W-1:0]  wlim_q;
    logic              start_x, end_x, match;
    logic              restart;

    scope_trig_regs #(
        .ANA_W(ANA_W), .LA_W(LA_W), .WID_W(WID_W), .HOLD_W(HOLD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .lock     (armed),
        .thr      (thr_q),
        .falling  (falling_q),
        .mode     (mode_q),
        .enable   (enable_q),
        .pattern  (pat_q),
        .mask     (mask_q),
        .holdoff  (hold_q),
        .width_lim(wlim_q)
    );

    scope_trig_detect #(
        .ANA_W(ANA_W), .LA_W(LA_W)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .sample  (ana_sample),
        .thr     (thr_q),
        .falling (falling_q),
        .la      (la_sample),
        .pattern (pat_q),
        .mask    (mask_q),
        .start_x (start_x),
        .end_x   (end_x),
        .match   (match)
    );

    scope_trig_fsm #(
        .WID_W(WID_W), .HOLD_W(HOLD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .fsm_reset (fsm_reset),
        .tick      (tick),
        .start_x   (start_x),
        .end_x     (end_x),
        .match     (match),
        .mode      (mode_q),
        .enable    (enable_q),
        .holdoff   (hold_q),
        .width_lim (wlim_q),
        .restart   (restart),
        .trig_pulse(trig_pulse),
        .armed     (armed),
        .triggered (triggered)
    );

endmodule

// File: rtl/scope_trig_checker.sv
module scope_trig_checker #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             fsm_reset,
    input logic             trig_pulse,
    input logic             triggered,
    input logic             armed,
    input logic             cfg_enable,
    input logic [CFG_W-1:0] cfg_word
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R10

    AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(tick)); // R10

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered); // R10

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && triggered)); // R13

    AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_reset |=> (!armed && !triggered)); // R12

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(cfg_word)); // R11

    AST_FIRE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> cfg_enable); // R5

endmodule

bind scope_trig_unit scope_trig_checker #(.CFG_W(CFG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fsm_reset (fsm_reset),
    .trig_pulse(trig_pulse),
    .triggered (triggered),
    .armed     (armed),
    .cfg_enable(enable_q),
    .cfg_word  ({thr_q, falling_q, mode_q, enable_q, pat_q, mask_q, hold_q, wlim_q})
);

// File: tb/scope_trig_unit_test.sv
`timescale 1ns/1ps
module scope_trig_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       arm = 1'b0;
    logic       fsm_reset = 1'b0;
    logic       tick = 1'b0;
    logic [9:0] ana_sample = '0;
    logic [7:0] la_sample = '0;
    logic       trig_pulse, triggered, armed;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scope_trig_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .arm(arm), .fsm_reset(fsm_reset), .tick(tick),
        .ana_sample(ana_sample), .la_sample(la_sample),
        .trig_pulse(trig_pulse), .triggered(triggered), .armed(armed)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr[3:0]; cfg_wdata = data[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic do_rst();
        @(negedge clk); fsm_reset = 1'b1;
        @(negedge clk); fsm_reset = 1'b0;
    endtask

    task automatic smp(input int a, input int l, input int exp, input string tag);
        @(negedge clk);
        tick = 1'b1; ana_sample = a[9:0]; la_sample = l[7:0];
        @(negedge clk);
        tick = 1'b0;
        check(trig_pulse == exp[0], tag, trig_pulse, exp);
    endtask

    task automatic t_reset();
        check(!trig_pulse && !triggered && !armed, "R1 outputs after reset",
              {trig_pulse, triggered, armed}, 0);
        wr(4, 8'hE0);
        do_arm();
        check(armed == 1'b1, "R1 zero holdoff arms straight to search", armed, 1);
        smp(0, 8'h01, 0, "R1 zero pattern/mask rejects 0x01");
        smp(0, 8'h00, 1, "R1 zero pattern/mask matches 0x00");
    endtask

    task automatic t_level_rise();
        do_rst();
        wr(3, 8'h00); wr(4, 8'h9A);
        do_arm();
        check(armed == 1'b1, "R13 armed after arm", armed, 1);
        smp(10'h300, 0, 0, "R3 first tick has no previous");
        smp(10'h100, 0, 0, "R3 fall ignored in rising mode");
        smp(10'h1FF, 0, 0, "R3 just below threshold 0x200");
        smp(10'h200, 0, 1, "R2 R3 rising crossing at equal code fires");
        check(triggered && !armed, "R10 triggered held, R13 not armed",
              {triggered, armed}, 2);
        smp(10'h000, 0, 0, "R10 pulse lasts one cycle");
        smp(10'h300, 0, 0, "R10 no second trigger per arm");
        check(triggered == 1'b1, "R10 triggered still held", triggered, 1);
    endtask

    task automatic t_level_fall();
        do_rst();
        wr(4, 8'h86);
        do_arm();
        smp(10'h100, 0, 0, "R3 falling: first tick");
        smp(10'h300, 0, 0, "R3 rising ignored in falling mode");
        smp(10'h200, 0, 0, "R3 equal code still above");
        smp(10'h1FF, 0, 1, "R3 falling crossing fires");
    endtask

    task automatic t_disabled();
        do_rst();
        wr(4, 8'h02);
        do_arm();
        smp(10'h100, 0, 0, "R5 disabled first tick");
        smp(10'h300, 0, 0, "R5 disabled crossing no fire");
        check(armed && !triggered, "R5 stays armed while disabled",
              {armed, triggered}, 2);
    endtask

    task automatic t_pattern();
        do_rst();
        wr(4, 8'hE0); wr(5, 8'hA5); wr(6, 8'h0F);
        do_arm();
        smp(10'h000, 8'h5A, 0, "R4 mismatch high nibble");
        smp(10'h3FF, 8'hB5, 0, "R4 analog crossing ignored, mismatch");
        smp(10'h000, 8'hA0, 1, "R4 masked nibble ignored, match fires");
    endtask

    task automatic t_holdoff();
        do_rst();
        wr(3, 8'h00); wr(4, 8'h82); wr(7, 8'h03); wr(8, 8'h00);
        do_arm();
        smp(10'h000, 0, 0, "R6 holdoff tick 1");
        smp(10'h300, 0, 0, "R6 crossing inside holdoff ignored");
        smp(10'h000, 0, 0, "R6 last holdoff tick");
        smp(10'h300, 0, 1, "R6 crossing after holdoff fires");
        wr(7, 8'h02); wr(8, 8'h01);
        do_arm();
        for (int i = 0; i < 258; i++)
            smp((i % 2) ? 10'h300 : 10'h000, 0, 0, "R6 R2 holdoff 0x0102 blocks");
        smp(10'h000, 0, 0, "R6 falling after holdoff");
        smp(10'h300, 0, 1, "R6 R2 fires after 258-tick holdoff");
        wr(7, 8'h00); wr(8, 8'h00);
    endtask

    task automatic t_narrow();
        do_rst();
        wr(4, 8'hA2); wr(11, 8'd3);
        do_arm();
        smp(10'h000, 0, 0, "R7 setup");
        smp(10'h300, 0, 0, "R7 start");
        smp(10'h300, 0, 0, "R7 width 2");
        smp(10'h300, 0, 0, "R7 width 3");
        smp(10'h000, 0, 0, "R7 width equal to limit rejected");
        check(armed == 1'b1, "R7 resumes search", armed, 1);
        smp(10'h300, 0, 0, "R7 second start");
        smp(10'h300, 0, 0, "R7 width 2");
        smp(10'h000, 0, 1, "R7 width below limit fires");
    endtask

    task automatic t_wide();
        do_rst();
        wr(4, 8'hC2); wr(11, 8'd3);
        do_arm();
        smp(10'h000, 0, 0, "R8 setup");
        smp(10'h300, 0, 0, "R8 start");
        smp(10'h300, 0, 0, "R8 width 2");
        smp(10'h000, 0, 0, "R8 width 2 rejected");
        smp(10'h300, 0, 0, "R8 second start");
        smp(10'h300, 0, 0, "R8 width 2");
        smp(10'h300, 0, 0, "R8 width 3");
        smp(10'h000, 0, 1, "R8 width equal to limit fires");
    endtask

    task automatic t_saturate();
        do_rst();
        wr(4, 8'hC2); wr(11, 8'hFF);
        do_arm();
        smp(10'h000, 0, 0, "R9 setup");
        for (int i = 0; i < 300; i++)
            smp(10'h300, 0, 0, "R9 long pulse high");
        smp(10'h000, 0, 1, "R9 300-tick pulse passes limit 255");
    endtask

    task automatic t_lock();
        do_rst();
        wr(3, 8'h00); wr(4, 8'h82);
        do_arm();
        wr(3, 8'hFF); wr(4, 8'h02);
        smp(10'h100, 0, 0, "R11 locked setup");
        smp(10'h250, 0, 1, "R11 writes while armed ignored");
        wr(3, 8'hFF);
        do_arm();
        smp(10'h100, 0, 0, "R11 new threshold setup");
        smp(10'h250, 0, 0, "R11 below new threshold 0x2FF");
        smp(10'h2FF, 0, 1, "R11 write in FIRED took effect");
        wr(3, 8'h00);
    endtask

    task automatic t_fsm_reset();
        do_rst();
        wr(4, 8'h82);
        do_arm();
        check(armed == 1'b1, "R12 armed before reset", armed, 1);
        do_rst();
        check(!armed && !triggered, "R12 reset returns to idle",
              {armed, triggered}, 0);
        smp(10'h000, 0, 0, "R12 idle ignores ticks");
        smp(10'h300, 0, 0, "R12 idle crossing no fire");
        @(negedge clk); arm = 1'b1; fsm_reset = 1'b1;
        @(negedge clk); arm = 1'b0; fsm_reset = 1'b0;
        check(armed == 1'b0, "R12 reset beats arm", armed, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_rise();
        t_level_fall();
        t_disabled();
        t_pattern();
        t_holdoff();
        t_narrow();
        t_wide();
        t_saturate();
        t_lock();
        t_fsm_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule